// File: doc/BRIEF.md
# Rename Group Free-Register Gate

This block decides, every cycle, whether the rename stage may take a whole group of up to four instructions at once. It looks at descriptors from the head of one of two instruction sources. The normal incoming queue is the usual source. The skid buffer is used instead while the stage is unblocking. Each descriptor gives a destination-register count for each register class and a set of type flags.

The block walks the selected group from the head and stops early when a memory queue is full or a serialization rule applies. It adds up the destination demand for each class. For the classes that need a worst-case reservation, it raises that demand to the rename width. It then compares every class's demand against the free physical register count for that class.

The result is a single all-or-nothing allow signal, valid in the same cycle as its inputs. There is also a one-cycle stall strobe that a statistics counter can add up.

Top module: `rngate_group_gate`

## Requirements
- R1: At most min(W, available count) slots are examined, starting at slot 0 (the head). The available count is a 3-bit input. Slot i of a descriptor bus occupies bits [20i+19:20i]. Within a descriptor:
  - bits [2c+1:2c] hold the 2-bit destination count for class c;
  - bit 12 is load, bit 13 is store and bit 14 is atomic;
  - bit 15 is squashed;
  - bit 16 is serialize-before, bit 17 is serialize-after and bit 18 is store-conditional;
  - bit 19 means the serialization has already been handled.
- R2: When `unblocking` is 1, the skid-buffer descriptors and count are used. Otherwise the normal-queue descriptors and count are used, and the other source has no effect on the outputs.
- R3: The free load-queue and store-queue counts are signed 8-bit values.
  - A load whose free load-queue count is zero or negative ends the scan without adding demand.
  - A store or atomic whose free store-queue count is zero or negative does the same.
- R4: A squashed slot that passes the queue checks adds no demand, and the scan continues past it.
- R5: A serialize-before slot that has not been handled ends the scan without adding demand.
- R6: A store-conditional or serialize-after slot that has not been handled adds its demand, and then the scan ends.
- R7: The demand of each class is the sum of its counts over the counted slots. For classes 0, 1, 2 and 5, the demand is raised to W whenever the sum is smaller. Classes 3 and 4 keep the plain sum.
- R8: `renameOk` is 1 exactly when, for every class c, the demand is no greater than the unsigned free count at `freeRegs[8c+7:8c]`.
- R9: `stallEvent` is 1 exactly when `renameOk` is 0 and the selected available count is nonzero. With zero available instructions, there is no stall, but `renameOk` still reflects the padded check.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, used only by the embedded checks |
| rstN | input | 1 | Active-low reset, disables the checks |
| unblocking | input | 1 | Selects the skid buffer as the source |
| normAvail | input | 3 | Instructions available in the normal queue |
| skidAvail | input | 3 | Instructions available in the skid buffer |
| normDesc | input | 80 | Normal-queue head descriptors, slot 0 in the low bits |
| skidDesc | input | 80 | Skid-buffer head descriptors, slot 0 in the low bits |
| freeLq | input | 8 | Signed free load-queue entries |
| freeSq | input | 8 | Signed free store-queue entries |
| freeRegs | input | 48 | Free physical registers per class, 8 bits each |
| renameOk | output | 1 | The whole group may be renamed this cycle |
| stallEvent | output | 1 | Group blocked for lack of registers |

## Verification
An early stop of the scan and the worst-case padding can both act in the same cycle. When a queue-full load, a serialize-before slot or a serialize-after slot cuts the group short, the truncated sum falls below W, and the padding must take over. Vectors are built in which the stopped group would pass or fail differently with and without the stop, and with and without the padding. The allow output is judged against an independent reference model, over directed vectors and thousands of random groups. Those random groups include all-squashed groups and groups that stop at slot 0.

// File: rtl/rngate_pkg.sv
package rngate_pkg;
  localparam int RN_W      = 4;
  localparam int NUM_CLS   = 6;
  localparam int CNT_W     = 2;
  localparam int FREE_W    = 8;
  localparam int AVAIL_W   = 3;
  localparam int FLAG_N    = 8;
  localparam int FLAG_BASE = NUM_CLS * CNT_W;
  localparam int DESC_W    = FLAG_BASE + FLAG_N;
  localparam logic [NUM_CLS-1:0] PAD_MASK = 6'b100111;

  // flag positions inside the flag byte
  localparam int F_LOAD   = 0;
  localparam int F_STORE  = 1;
  localparam int F_ATOMIC = 2;
  localparam int F_SQUASH = 3;
  localparam int F_SERB   = 4;
  localparam int F_SERA   = 5;
  localparam int F_SC     = 6;
  localparam int F_DONE   = 7;

  typedef struct packed {
    logic            srcSkid;
    logic            groupLive;
    logic [RN_W-1:0] seen;
    logic [RN_W-1:0] countEn;
  } scanStrobes_t;
endpackage

// File: rtl/rngate_scan_ctrl.sv
module rngate_scan_ctrl
  import rngate_pkg::*;
#(
  parameter int RW = RN_W,
  parameter int DW = DESC_W,
  parameter int FB = FLAG_BASE,
  parameter int AW = AVAIL_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               unblocking,
  input  logic [AW-1:0]      normAvail,
  input  logic [AW-1:0]      skidAvail,
  input  logic [RW*DW-1:0]   normDesc,
  input  logic [RW*DW-1:0]   skidDesc,
  input  logic signed [7:0]  freeLq,
  input  logic signed [7:0]  freeSq,
  output scanStrobes_t       strobes
);
  logic [RW*DW-1:0] selDesc;
  logic [AW-1:0]    selAvail;
  int               effN;
  logic             lqFull, sqFull;
  logic [FLAG_N-1:0] slotFlags [RW];

  assign selDesc  = unblocking ? skidDesc : normDesc;
  assign selAvail = unblocking ? skidAvail : normAvail;
  assign lqFull   = (freeLq <= 8'sd0);
  assign sqFull   = (freeSq <= 8'sd0);
  assign effN     = (int'(selAvail) > RW) ? RW : int'(selAvail);

  always_comb begin
    for (int i = 0; i < RW; i++) slotFlags[i] = selDesc[i*DW+FB +: FLAG_N];
  end

  always_comb begin
    logic going;
    going = 1'b1;
    strobes.srcSkid   = unblocking;
    strobes.groupLive = (effN != 0);
    strobes.seen      = '0;
    strobes.countEn   = '0;
    for (int i = 0; i < RW; i++) begin
      if (going && i < effN) begin
        strobes.seen[i] = 1'b1;
        if (slotFlags[i][F_LOAD] && lqFull) begin
          going = 1'b0;
        end else if ((slotFlags[i][F_STORE] || slotFlags[i][F_ATOMIC]) && sqFull) begin
          going = 1'b0;
        end else if (slotFlags[i][F_SQUASH]) begin
          going = 1'b1;
        end else if (slotFlags[i][F_SERB] && !slotFlags[i][F_DONE]) begin
          going = 1'b0;
        end else begin
          strobes.countEn[i] = 1'b1;
          if ((slotFlags[i][F_SC] || slotFlags[i][F_SERA]) && !slotFlags[i][F_DONE])
            going = 1'b0;
        end
      end
    end
  end

  // examined slots form a run from the head
  assert_seen_prefix_R1: assert property (@(posedge clk) disable iff (!rstN)
    ((strobes.seen + 1'b1) & strobes.seen) == '0);
  assert_seen_bound_R1: assert property (@(posedge clk) disable iff (!rstN)
    $countones(strobes.seen) <= int'(selAvail));

  for (genvar g = 0; g < RW; g++) begin : g_slotChk
    assert_squash_skip_R4: assert property (@(posedge clk) disable iff (!rstN)
      strobes.countEn[g] |-> !slotFlags[g][F_SQUASH]);
    assert_serb_block_R5: assert property (@(posedge clk) disable iff (!rstN)
      strobes.countEn[g] |-> !(slotFlags[g][F_SERB] && !slotFlags[g][F_DONE]));
  end
endmodule

// File: rtl/rngate_demand_dp.sv
module rngate_demand_dp
  import rngate_pkg::*;
#(
  parameter int RW = RN_W,
  parameter int NC = NUM_CLS,
  parameter int CW = CNT_W,
  parameter int FW = FREE_W,
  parameter int DW = DESC_W,
  parameter logic [NC-1:0] PAD = PAD_MASK
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [RW*DW-1:0] normDesc,
  input  logic [RW*DW-1:0] skidDesc,
  input  scanStrobes_t     strobes,
  input  logic [NC*FW-1:0] freeRegs,
  output logic             renameOk
);
  localparam int SUM_MAX = RW * ((1 << CW) - 1);
  localparam int DMW     = $clog2((SUM_MAX > RW ? SUM_MAX : RW) + 1);

  logic [RW*DW-1:0] selDesc;
  logic [DMW-1:0]   demand  [NC];
  logic [NC-1:0]    classOk;

  assign selDesc = strobes.srcSkid ? skidDesc : normDesc;

  for (genvar c = 0; c < NC; c++) begin : g_cls
    logic [DMW-1:0] rawSum;
    always_comb begin
      rawSum = '0;
      for (int i = 0; i < RW; i++) begin
        if (strobes.countEn[i])
          rawSum = rawSum + DMW'(selDesc[i*DW + c*CW +: CW]);
      end
    end
    if (PAD[c]) begin : g_pad
      assign demand[c] = (int'(rawSum) < RW) ? DMW'(RW) : rawSum;
      assert_pad_floor_R7: assert property (@(posedge clk) disable iff (!rstN)
        int'(demand[c]) >= RW);
      assert_allow_cover_R8: assert property (@(posedge clk) disable iff (!rstN)
        renameOk |-> int'(freeRegs[c*FW +: FW]) >= RW);
    end else begin : g_raw
      assign demand[c] = rawSum;
    end
    assign classOk[c] = int'(demand[c]) <= int'(freeRegs[c*FW +: FW]);
  end

  assign renameOk = &classOk;
endmodule

// File: rtl/rngate_group_gate.sv
module rngate_group_gate
  import rngate_pkg::*;
#(
  parameter int RW = RN_W,
  parameter int NC = NUM_CLS,
  parameter int FW = FREE_W,
  parameter int AW = AVAIL_W,
  parameter int DW = DESC_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  unblocking,
  input  logic [AW-1:0]         normAvail,
  input  logic [AW-1:0]         skidAvail,
  input  logic [RW*DW-1:0]      normDesc,
  input  logic [RW*DW-1:0]      skidDesc,
  input  logic signed [7:0]     freeLq,
  input  logic signed [7:0]     freeSq,
  input  logic [NC*FW-1:0]      freeRegs,
  output logic                  renameOk,
  output logic                  stallEvent
);
  scanStrobes_t strobes;

  rngate_scan_ctrl #(.RW(RW), .DW(DW), .FB(FLAG_BASE), .AW(AW)) ctrl_i (
    .clk(clk), .rstN(rstN), .unblocking(unblocking),
    .normAvail(normAvail), .skidAvail(skidAvail),
    .normDesc(normDesc), .skidDesc(skidDesc),
    .freeLq(freeLq), .freeSq(freeSq), .strobes(strobes));

  rngate_demand_dp #(.RW(RW), .NC(NC), .CW(CNT_W), .FW(FW), .DW(DW), .PAD(PAD_MASK)) dp_i (
    .clk(clk), .rstN(rstN), .normDesc(normDesc), .skidDesc(skidDesc),
    .strobes(strobes), .freeRegs(freeRegs), .renameOk(renameOk));

  assign stallEvent = !renameOk && strobes.groupLive;

  assert_no_idle_stall_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((unblocking ? skidAvail : normAvail) == '0) |-> !stallEvent);
  assert_src_follow_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.srcSkid == unblocking);
endmodule

// File: tb/rngate_group_gate_tb_top.sv
module rngate_group_gate_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic        unblocking;
  logic [2:0]  normAvail, skidAvail;
  logic [79:0] normDesc, skidDesc;
  logic signed [7:0] freeLq, freeSq;
  logic [47:0] freeRegs;
  logic        renameOk, stallEvent;

  int nVec = 0;
  int nMis = 0;

  rngate_group_gate dut_i (
    .clk(clk), .rstN(rstN), .unblocking(unblocking),
    .normAvail(normAvail), .skidAvail(skidAvail),
    .normDesc(normDesc), .skidDesc(skidDesc),
    .freeLq(freeLq), .freeSq(freeSq), .freeRegs(freeRegs),
    .renameOk(renameOk), .stallEvent(stallEvent));

  typedef struct packed {
    logic        ub;
    logic [2:0]  nAv;
    logic [2:0]  sAv;
    logic [79:0] nD;
    logic [79:0] sD;
    logic [7:0]  lq;
    logic [7:0]  sq;
    logic [47:0] fr;
    logic        ok;
    logic        st;
  } vec_t;

  localparam logic [19:0] I1  = 20'h00001;  // one class-0 dest
  localparam logic [19:0] I3  = 20'h00003;  // three class-0 dests
  localparam logic [19:0] C2  = 20'h00200;  // two class-4 dests
  localparam logic [19:0] LC2 = 20'h01200;  // load, two class-4 dests
  localparam logic [19:0] SA3 = 20'h20003;  // serialize-after, unhandled
  localparam logic [19:0] SB3 = 20'h10003;  // serialize-before, unhandled
  localparam logic [19:0] SQ3 = 20'h08003;  // squashed
  localparam logic [19:0] ST3 = 20'h02003;  // store

  localparam vec_t VECS [12] = '{
    '{1'b0, 3'd4, 3'd0, {4{I1}}, 80'd0, 8'd5, 8'd5, {6{8'd4}}, 1'b1, 1'b0},         // R7 R8 pad meets free
    '{1'b0, 3'd4, 3'd0, {4{I1}}, 80'd0, 8'd5, 8'd5, {6{8'd3}}, 1'b0, 1'b1},         // R7 R9 pad exceeds free
    '{1'b0, 3'd4, 3'd0, {4{C2}}, 80'd0, 8'd5, 8'd5, {6{8'd7}}, 1'b0, 1'b1},         // R7 unpadded class sum 8
    '{1'b0, 3'd4, 3'd0, {C2,C2,C2,LC2}, 80'd0, 8'd0, 8'd5, {6{8'd7}}, 1'b1, 1'b0},  // R3 load stops at head
    '{1'b1, 3'd0, 3'd2, {4{I1}}, {4{I3}}, 8'd5, 8'd5, {6{8'd5}}, 1'b0, 1'b1},       // R2 skid selected
    '{1'b0, 3'd0, 3'd3, {4{I3}}, {4{I3}}, 8'd5, 8'd5, {6{8'd4}}, 1'b1, 1'b0},       // R2 R9 skid ignored, idle
    '{1'b0, 3'd0, 3'd0, {4{I3}}, {4{I3}}, 8'd5, 8'd5, {6{8'd3}}, 1'b0, 1'b0},       // R9 idle no stall
    '{1'b0, 3'd4, 3'd0, {I3,I3,SA3,I3}, 80'd0, 8'd5, 8'd5, {6{8'd6}}, 1'b1, 1'b0},  // R6 count then stop
    '{1'b0, 3'd4, 3'd0, {I3,I3,I3,SB3}, 80'd0, 8'd5, 8'd5, {6{8'd4}}, 1'b1, 1'b0},  // R5 stop before count
    '{1'b0, 3'd4, 3'd0, {4{SQ3}}, 80'd0, 8'd5, 8'd5, {6{8'd4}}, 1'b1, 1'b0},        // R4 all squashed
    '{1'b0, 3'd2, 3'd0, {4{I3}}, 80'd0, 8'd5, 8'd5, {6{8'd6}}, 1'b1, 1'b0},         // R1 only two examined
    '{1'b0, 3'd4, 3'd0, {I3,I3,I3,ST3}, 80'd0, 8'd5, 8'hFF, {6{8'd4}}, 1'b1, 1'b0}  // R3 negative store room
  };

  // independent reference: returns {ok, stall}
  function automatic logic [1:0] refGate(input logic ub, input logic [2:0] nAv, input logic [2:0] sAv,
      input logic [79:0] nD, input logic [79:0] sD, input logic signed [7:0] lq,
      input logic signed [7:0] sq, input logic [47:0] fr);
    logic [79:0] d;
    int n, slot, need [6];
    logic ok, stop;
    logic [19:0] e;
    d = ub ? sD : nD;
    n = ub ? int'(sAv) : int'(nAv);
    if (n > 4) n = 4;
    for (int c = 0; c < 6; c++) need[c] = 0;
    slot = 0;
    stop = 1'b0;
    while (!stop && slot < n) begin
      e = d[slot*20 +: 20];
      if (e[12] && lq <= 0) stop = 1'b1;
      else if ((e[13] || e[14]) && sq <= 0) stop = 1'b1;
      else if (!e[15]) begin
        if (e[16] && !e[19]) stop = 1'b1;
        else begin
          for (int c = 0; c < 6; c++) need[c] += int'(e[2*c +: 2]);
          if ((e[17] || e[18]) && !e[19]) stop = 1'b1;
        end
      end
      slot++;
    end
    ok = 1'b1;
    for (int c = 0; c < 6; c++) begin
      if ((c <= 2 || c == 5) && need[c] < 4) need[c] = 4;
      if (need[c] > int'(fr[8*c +: 8])) ok = 1'b0;
    end
    return {ok, !ok && n != 0};
  endfunction

  task automatic drive(input vec_t v);
    @(negedge clk);
    unblocking = v.ub; normAvail = v.nAv; skidAvail = v.sAv;
    normDesc = v.nD; skidDesc = v.sD; freeLq = v.lq; freeSq = v.sq; freeRegs = v.fr;
    #2;
  endtask

  task automatic check(input string tag, input logic expOk, input logic expSt);
    nVec++;
    if (renameOk !== expOk || stallEvent !== expSt) begin
      nMis++;
      $display("FAIL %s: got ok=%b stall=%b expected ok=%b stall=%b",
               tag, renameOk, stallEvent, expOk, expSt);
    end
  endtask

  function automatic logic [19:0] rndDesc();
    logic [19:0] e;
    e[11:0] = 12'($urandom);
    e[19:12] = 8'($urandom) & 8'($urandom);  // sparse flags
    return e;
  endfunction

  initial begin
    #1500000;
    nMis++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nMis);
    $finish;
  end

  initial begin
    vec_t v;
    logic [1:0] exp;
    v = '0;
    drive(v);
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    drive(v);
    check("R8 R9 reset state, zero free", 1'b0, 1'b0);

    for (int k = 0; k < 12; k++) begin
      drive(VECS[k]);
      check($sformatf("table vector %0d", k), VECS[k].ok, VECS[k].st);
    end

    for (int k = 0; k < 3000; k++) begin
      v.ub  = 1'($urandom);
      v.nAv = 3'($urandom);
      v.sAv = 3'($urandom);
      for (int s = 0; s < 4; s++) begin
        v.nD[s*20 +: 20] = rndDesc();
        v.sD[s*20 +: 20] = rndDesc();
        if (k % 7 == 0) v.nD[s*20+15] = 1'b1;   // R4 all-squashed groups
      end
      if (k % 11 == 0) begin v.nD[16] = 1'b1; v.nD[19] = 1'b0; end // R5 head stop
      v.lq = 8'($signed(int'($urandom_range(6)) - 2));
      v.sq = 8'($signed(int'($urandom_range(6)) - 2));
      for (int c = 0; c < 6; c++) v.fr[8*c +: 8] = 8'($urandom_range(14));
      exp = refGate(v.ub, v.nAv, v.sAv, v.nD, v.sD, v.lq, v.sq, v.fr);
      drive(v);
      check("R1 R2 R3 R4 R5 R6 R7 R8 R9 random", exp[1], exp[0]);
    end

    // R3: negative load room blocks load at head; padding alone decides
    v = VECS[3]; v.lq = 8'hFE;
    drive(v);
    check("R3 negative load room", 1'b1, 1'b0);
    // R6: handled serialize-after does not stop, full 12 demand vs 6 free
    v = VECS[7]; v.nD[1*20+19] = 1'b1;
    drive(v);
    check("R6 handled serialize-after", 1'b0, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nMis);
    $finish;
  end
endmodule